// File: doc/BRIEF.md
# Dual 32-bit Timer/Counter

Two independent 32-bit timer/counters share one word-addressed register bus. Each timer has three registers: a control/status word, a load value and a live counter. A timer counts up or down from the value copied out of its load register. When it rolls over it either reloads and keeps running, which gives a periodic tick or a free-running counter, or it stops by clearing its own enable bit, which gives a one-shot.

Every rollover raises a sticky interrupt flag in the timer's control word. The flag clears only when software writes a 1 to it, so writing back the control word just read acknowledges the event. The single interrupt output is high while any timer has both its flag and its interrupt-enable bit set. An enable-all bit, written through either control word, starts both timers on the same clock. The capture, external-output and PWM control bits are kept as written and have no other effect.

Reads are combinational and have no side effects. A write takes effect at the next rising clock edge.

Top module: `tmr_dual`

## Requirements
- R1: After synchronous reset every register of both timers reads 0 and `irq_out` is low.
- R2: Timer n (n = 0 or 1) decodes byte address 0x10·n + 0x0 as control, + 0x4 as load, + 0x8 as counter, and + 0xC reads 0. Address bits 1:0 are ignored. The load register reads back the last value written to it.
- R3: Control bit positions: 0 capture mode, 1 count down, 2 output enable, 3 capture trigger enable, 4 auto-reload, 5 load, 6 interrupt enable, 7 timer enable, 8 interrupt flag, 9 PWM enable, 10 enable-all. Bits 0, 2, 3, 9 and 10 read back as written. Bits 31:11 read 0.
- R4: While control bit 5 is set, each clock edge copies the load register into the counter and the counter does not count, even with bit 7 set.
- R5: With bit 7 set, bits 5 and 1 clear, the counter increases by one on every clock edge.
- R6: With bits 7 and 1 set and bit 5 clear, the counter decreases by one on every clock edge.
- R7: A rollover is a step down from 0 or a step up from 0xFFFFFFFF. A rollover sets the interrupt flag (bit 8).
- R8: On a rollover with auto-reload (bit 4) set, the counter takes the load register value and bit 7 stays set.
- R9: On a rollover with auto-reload clear, the counter wraps (to 0xFFFFFFFF counting down, to 0 counting up), bit 7 clears and the counter then holds.
- R10: A control write with bit 8 = 1 clears the flag. With bit 8 = 0 it leaves the flag unchanged. A rollover in the same cycle as a clearing write leaves the flag set.
- R11: `irq_out` is high exactly when some timer has both bit 8 and bit 6 set.
- R12: A control write with bit 10 set, to either timer, sets bit 7 of both timers on that edge, so both counters advance from the next edge.
- R13: Writes to a counter address have no effect on the count.
- R14: With bits 7 and 5 both clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | OR of both timers' enabled interrupt flags |

## Verification
The counter register always shows the live count. A wrong step, a missed reload or an enable bit left set after a one-shot therefore shows up in the count on the first clock edge after the fault. A wrong flag or interrupt-enable state reaches `irq_out` in the same cycle the register changes. The clear-versus-set order of the flag is visible only if a clearing write lands on a rollover edge, so the bench mixes random control writes with short load values that roll over often. It checks every register of both timers against a cycle model after each edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int CTRL_W = 11;

    // Control word; the last field is bit 0.
    typedef struct packed {
        logic en_all;       // 10
        logic pwm_en;       // 9
        logic flag;         // 8
        logic run;          // 7
        logic irq_en;       // 6
        logic load;         // 5
        logic auto_rl;      // 4
        logic cap_trig;     // 3
        logic out_en;       // 2
        logic down;         // 1
        logic cap_mode;     // 0
    } tmr_ctrl_t;

    localparam int FLAG_BIT   = 8;
    localparam int EN_ALL_BIT = 10;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LOAD  = 2'd1,
        REG_COUNT = 2'd2,
        REG_NONE  = 2'd3
    } tmr_reg_e;

    function automatic tmr_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        return tmr_ctrl_t'(w[CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/tmr_count_step.sv
module tmr_count_step #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] load_q,
    input  logic             hold_load,
    input  logic             run,
    input  logic             down,
    input  logic             auto_rl,
    output logic [CNT_W-1:0] count_d,
    output logic             wrap
);

    always_comb begin
        wrap    = 1'b0;
        count_d = count_q;
        if (hold_load) begin
            count_d = load_q;
        end else if (run) begin
            if (down) begin
                wrap    = (count_q == '0);
                count_d = count_q - CNT_W'(1);
            end else begin
                wrap    = (count_q == '1);
                count_d = count_q + CNT_W'(1);
            end
            if (wrap && auto_rl) begin
                count_d = load_q;
            end
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_all,
    output tmr_ctrl_t         ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq_req
);

    logic [CNT_W-1:0] count_d;
    logic             wrap;
    tmr_ctrl_t        ctrl_d;

    tmr_count_step #(.CNT_W(CNT_W)) u_step (
        .count_q   (count_q),
        .load_q    (load_q),
        .hold_load (ctrl_q.load),
        .run       (ctrl_q.run),
        .down      (ctrl_q.down),
        .auto_rl   (ctrl_q.auto_rl),
        .count_d   (count_d),
        .wrap      (wrap)
    );

    // Written value first, then the enable side effects, then the flag.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d      = word_to_ctrl(wdata);
            ctrl_d.flag = ctrl_q.flag & ~wdata[FLAG_BIT];
        end else if (wrap && !ctrl_q.auto_rl) begin
            ctrl_d.run = 1'b0;
        end
        if (start_all) begin
            ctrl_d.run = 1'b1;
        end
        if (wrap) begin
            ctrl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            load_q  <= '0;
            count_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            count_q <= count_d;
            if (wr_load) begin
                load_q <= wdata[CNT_W-1:0];
            end
        end
    end

    assign irq_req = ctrl_q.flag & ctrl_q.irq_en;

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int CNT_W      = 32,
    localparam int IDX_W      = $clog2(NUM_TIMERS),
    localparam int ADDR_W     = IDX_W + 4
) (
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                wr_en_all,
    input  logic [NUM_TIMERS-1:0][CTRL_W-1:0]   ctrl_words,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]    load_words,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]    count_words,
    output logic [NUM_TIMERS-1:0]               wr_ctrl,
    output logic [NUM_TIMERS-1:0]               wr_load,
    output logic                                start_all,
    output logic [DATA_W-1:0]                   bus_rdata
);

    tmr_reg_e         sel;
    logic [IDX_W-1:0] idx;
    logic             unused_byte_lanes;

    assign sel               = tmr_reg_e'(bus_addr[3:2]);
    assign idx               = bus_addr[ADDR_W-1:4];
    assign unused_byte_lanes = ^bus_addr[1:0];

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_strobe
        assign wr_ctrl[g] = bus_wr && (idx == IDX_W'(g)) && (sel == REG_CTRL);
        assign wr_load[g] = bus_wr && (idx == IDX_W'(g)) && (sel == REG_LOAD);
    end

    assign start_all = (|wr_ctrl) && wr_en_all;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (idx == IDX_W'(i)) begin
                case (sel)
                    REG_CTRL:  bus_rdata = DATA_W'(ctrl_words[i]);
                    REG_LOAD:  bus_rdata = DATA_W'(load_words[i]);
                    REG_COUNT: bus_rdata = DATA_W'(count_words[i]);
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
    import tmr_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int CNT_W      = 32,
    localparam int ADDR_W     = $clog2(NUM_TIMERS) + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    tmr_ctrl_t                            ctrl_q [NUM_TIMERS];
    logic [NUM_TIMERS-1:0][CTRL_W-1:0]    ctrl_bits;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]     load_bits;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]     count_bits;
    logic [NUM_TIMERS-1:0]                wr_ctrl;
    logic [NUM_TIMERS-1:0]                wr_load;
    logic [NUM_TIMERS-1:0]                irq_req;
    logic                                 start_all;

    tmr_bus_decode #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_dec (
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .wr_en_all   (bus_wdata[EN_ALL_BIT]),
        .ctrl_words  (ctrl_bits),
        .load_words  (load_bits),
        .count_words (count_bits),
        .wr_ctrl     (wr_ctrl),
        .wr_load     (wr_load),
        .start_all   (start_all),
        .bus_rdata   (bus_rdata)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_ctrl   (wr_ctrl[g]),
            .wr_load   (wr_load[g]),
            .wdata     (bus_wdata),
            .start_all (start_all),
            .ctrl_q    (ctrl_q[g]),
            .load_q    (load_bits[g]),
            .count_q   (count_bits[g]),
            .irq_req   (irq_req[g])
        );
        assign ctrl_bits[g] = ctrl_q[g];
    end

    assign irq_out = |irq_req;

endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk
    import tmr_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int CNT_W      = 32,
    localparam int ADDR_W     = $clog2(NUM_TIMERS) + 4
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              bus_wr,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic [DATA_W-1:0]                 bus_wdata,
    input logic                              irq_out,
    input logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_bits,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0]  load_bits,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0]  count_bits
);

    logic any_pending;
    logic ctrl_wr_all;
    logic unused_chk_bits;

    always_comb begin
        any_pending = 1'b0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            any_pending = any_pending | (ctrl_bits[i][8] & ctrl_bits[i][6]);
        end
    end

    assign ctrl_wr_all     = bus_wr && (bus_addr[3:2] == 2'd0) && bus_wdata[EN_ALL_BIT];
    assign unused_chk_bits = ^{bus_addr[1:0], bus_addr[ADDR_W-1:4], bus_wdata};

    // R11: interrupt output tracks the enabled flags of all timers
    a_r11_irq_or: assert property (@(posedge clk) disable iff (rst)
        irq_out == any_pending);

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        // R4: load bit forces the load value into the counter
        a_r4_load_copy: assert property (@(posedge clk) disable iff (rst)
            ctrl_bits[g][5] |=> count_bits[g] == $past(load_bits[g]));

        // R14: stopped counter holds
        a_r14_hold: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_bits[g][7] && !ctrl_bits[g][5]) |=> $stable(count_bits[g]));

        // R5: up step
        a_r5_up_step: assert property (@(posedge clk) disable iff (rst)
            (ctrl_bits[g][7] && !ctrl_bits[g][5] && !ctrl_bits[g][1] && count_bits[g] != '1)
            |=> count_bits[g] == $past(count_bits[g]) + CNT_W'(1));

        // R6: down step
        a_r6_down_step: assert property (@(posedge clk) disable iff (rst)
            (ctrl_bits[g][7] && !ctrl_bits[g][5] && ctrl_bits[g][1] && count_bits[g] != '0)
            |=> count_bits[g] == $past(count_bits[g]) - CNT_W'(1));

        // R7: rollover when counting up raises the flag
        a_r7_up_flag: assert property (@(posedge clk) disable iff (rst)
            (ctrl_bits[g][7] && !ctrl_bits[g][5] && !ctrl_bits[g][1] && count_bits[g] == '1)
            |=> ctrl_bits[g][8]);

        // R9: one-shot stop when no bus write intervenes
        a_r9_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
            (!bus_wr && ctrl_bits[g][7] && !ctrl_bits[g][5] && !ctrl_bits[g][4]
             && ctrl_bits[g][1] && count_bits[g] == '0)
            |=> !ctrl_bits[g][7]);

        // R12: enable-all starts every timer
        a_r12_start_all: assert property (@(posedge clk) disable iff (rst)
            ctrl_wr_all |=> ctrl_bits[g][7]);
    end

endmodule

bind tmr_dual tmr_dual_chk #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_out    (irq_out),
    .ctrl_bits  (ctrl_bits),
    .load_bits  (load_bits),
    .count_bits (count_bits)
);

// File: tb/tmr_dual_tb.sv
module tmr_dual_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    logic [10:0] m_ctrl [2];
    logic [31:0] m_load [2];
    logic [31:0] m_cnt  [2];

    always #10 clk = ~clk;

    tmr_dual u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        chk(req, {31'b0, irq_out}, {31'b0, exp});
    endtask

    function automatic logic model_irq();
        return (m_ctrl[0][8] & m_ctrl[0][6]) | (m_ctrl[1][8] & m_ctrl[1][6]);
    endfunction

    // Cycle model of both timers, written from the requirements.
    task automatic model_step(input logic wr, input logic [4:0] a, input logic [31:0] d);
        logic sa;
        sa = wr && (a[3:2] == 2'd0) && d[10];
        for (int i = 0; i < 2; i++) begin
            logic [31:0] c;
            logic [31:0] nc;
            logic [10:0] k;
            logic [10:0] nk;
            logic        wrap;
            logic        hit;
            c = m_cnt[i];
            k = m_ctrl[i];
            nc = c;
            wrap = 1'b0;
            hit = wr && (int'(a[4]) == i);
            if (k[5]) begin
                nc = m_load[i];
            end else if (k[7]) begin
                if (k[1]) begin
                    wrap = (c == 32'h0);
                    nc = c - 32'd1;
                end else begin
                    wrap = (c == 32'hFFFF_FFFF);
                    nc = c + 32'd1;
                end
                if (wrap && k[4]) nc = m_load[i];
            end
            nk = k;
            if (hit && a[3:2] == 2'd0) begin
                nk = d[10:0];
                nk[8] = k[8] & ~d[8];
            end else if (wrap && !k[4]) begin
                nk[7] = 1'b0;
            end
            if (sa) nk[7] = 1'b1;
            if (wrap) nk[8] = 1'b1;
            if (hit && a[3:2] == 2'd1) m_load[i] = d;
            m_cnt[i]  = nc;
            m_ctrl[i] = nk;
        end
    endtask

    task automatic tick(input logic wr, input logic [4:0] a, input logic [31:0] d);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_step(wr, a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) tick(1'b0, 5'h00, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        for (int i = 0; i < 2; i++) begin
            m_ctrl[i] = '0;
            m_load[i] = '0;
            m_cnt[i]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1", 5'h00, 32'h0);
        rd_chk("R1", 5'h04, 32'h0);
        rd_chk("R1", 5'h08, 32'h0);
        rd_chk("R1", 5'h10, 32'h0);
        rd_chk("R1", 5'h14, 32'h0);
        rd_chk("R1", 5'h18, 32'h0);
        irq_chk("R1", 1'b0);

        // R3 stored bits and upper bits
        tick(1'b1, 5'h00, 32'h0000_020D);
        rd_chk("R3", 5'h00, 32'h0000_020D);
        tick(1'b1, 5'h00, 32'hFFFF_F80D);
        rd_chk("R3", 5'h00, 32'h0000_000D);

        // R2 map, R13 counter write ignored
        tick(1'b1, 5'h04, 32'h1234_5678);
        tick(1'b1, 5'h14, 32'hCAFE_0001);
        rd_chk("R2", 5'h04, 32'h1234_5678);
        rd_chk("R2", 5'h15, 32'hCAFE_0001);
        tick(1'b1, 5'h08, 32'h0000_DEAD);
        rd_chk("R13", 5'h08, 32'h0);
        rd_chk("R2", 5'h0C, 32'h0);
        rd_chk("R2", 5'h1C, 32'h0);
        tick(1'b1, 5'h00, 32'h0);

        // R4 load bit
        tick(1'b1, 5'h00, 32'h20);
        idle(1);
        rd_chk("R4", 5'h08, 32'h1234_5678);
        tick(1'b1, 5'h00, 32'hA0);
        idle(3);
        rd_chk("R4", 5'h08, 32'h1234_5678);

        // R5 up count
        tick(1'b1, 5'h00, 32'h80);
        idle(5);
        rd_chk("R5", 5'h08, 32'h1234_567D);

        // R14 hold
        tick(1'b1, 5'h00, 32'h00);
        idle(3);
        rd_chk("R14", 5'h08, 32'h1234_567E);

        // R6 down, R9 one-shot, R7 flag, R11 irq
        tick(1'b1, 5'h04, 32'd3);
        tick(1'b1, 5'h00, 32'h20);
        idle(1);
        tick(1'b1, 5'h00, 32'hC2);
        idle(1);
        rd_chk("R6", 5'h08, 32'd2);
        idle(3);
        rd_chk("R9", 5'h08, 32'hFFFF_FFFF);
        rd_chk("R7", 5'h00, 32'h0000_0142);
        irq_chk("R11", 1'b1);
        idle(2);
        rd_chk("R9", 5'h08, 32'hFFFF_FFFF);

        // R10 write-one-to-clear
        tick(1'b1, 5'h00, 32'h042);
        rd_chk("R10", 5'h00, 32'h0000_0142);
        tick(1'b1, 5'h00, 32'h142);
        rd_chk("R10", 5'h00, 32'h0000_0042);
        irq_chk("R11", 1'b0);

        // R8 auto-reload down on timer 1
        tick(1'b1, 5'h14, 32'd2);
        tick(1'b1, 5'h10, 32'h20);
        idle(1);
        tick(1'b1, 5'h10, 32'h92);
        idle(3);
        rd_chk("R8", 5'h18, 32'd2);
        rd_chk("R8", 5'h10, 32'h0000_0192);
        irq_chk("R11", 1'b0);
        idle(1);
        rd_chk("R8", 5'h18, 32'd1);
        tick(1'b1, 5'h10, 32'h100);

        // R7 rollover counting up with reload
        tick(1'b1, 5'h04, 32'hFFFF_FFFE);
        tick(1'b1, 5'h00, 32'h20);
        idle(1);
        tick(1'b1, 5'h00, 32'h90);
        idle(2);
        rd_chk("R8", 5'h08, 32'hFFFF_FFFE);
        rd_chk("R7", 5'h00, 32'h0000_0190);
        tick(1'b1, 5'h00, 32'h100);

        // R12 enable-all
        tick(1'b1, 5'h04, 32'd100);
        tick(1'b1, 5'h14, 32'd200);
        tick(1'b1, 5'h00, 32'h20);
        tick(1'b1, 5'h10, 32'h20);
        tick(1'b1, 5'h00, 32'h00);
        tick(1'b1, 5'h10, 32'h00);
        tick(1'b1, 5'h10, 32'h400);
        rd_chk("R12", 5'h00, 32'h0000_0080);
        rd_chk("R12", 5'h10, 32'h0000_0480);
        idle(4);
        rd_chk("R12", 5'h08, 32'd104);
        rd_chk("R12", 5'h18, 32'd204);

        // Random phase against the cycle model
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [4:0]  a;
            logic [31:0] d;
            r = int'($urandom % 10);
            if (r < 5) begin
                tick(1'b0, 5'h00, 32'h0);
            end else begin
                a = {1'($urandom % 2), 2'($urandom % 3), 2'b00};
                if (a[3:2] == 2'd1) begin
                    d = ($urandom % 2 == 0) ? 32'($urandom % 16)
                                            : 32'hFFFF_FFF0 + 32'($urandom % 16);
                end else begin
                    d = $urandom & 32'h0000_03FF;
                    if ($urandom % 8 == 0) d = d | 32'h400;
                end
                tick(1'b1, a, d);
            end
            for (int i = 0; i < 2; i++) begin
                rd_chk("R10", 5'(i * 16),     {21'b0, m_ctrl[i]});
                rd_chk("R2",  5'(i * 16 + 4), m_load[i]);
                rd_chk("R8",  5'(i * 16 + 8), m_cnt[i]);
            end
            irq_chk("R11", model_irq());
        end

        finish_run();
    end

endmodule